// File: doc/BRIEF.md
# Programmable Timer with Modulo Reload

This block is a small timer peripheral that sits on a byte-wide register bus. It holds a free-running prescaler whose upper byte can be read as a divider value, an up-counter that advances at one of four programmable rates derived from the system clock, a modulo register that supplies the counter's restart value, and a control register holding a run bit and a two-bit rate select.

Software picks a rate and sets the run bit. Each time the counter steps past its all-ones value, it reloads from the modulo register on that same tick and the block raises a single-cycle interrupt request. An interrupt controller elsewhere latches this pulse. Writing any value to the divider address zeroes the whole prescaler, which lets software align the tick phase. The count tick is taken from the falling edge of the selected prescaler bit after it has been gated with the run bit. A change of rate or of the run bit can therefore produce one extra count, and software is expected to allow for this.

Top module: `prog_timer`

## Requirements
- R1: After reset, all four registers read 0x00 and `irq_o` is low.
- R2: Register addresses are 0 = divider, 1 = counter, 2 = modulo, 3 = control. Control bit 2 is the run bit and control bits 1:0 are the rate select. A control read returns those three bits with bits 7:3 as zero. The modulo register reads back the last value written to it.
- R3: With the run bit set, the counter advances by exactly one every P clocks. P is 1024 for rate 00, 16 for rate 01, 64 for rate 10 and 256 for rate 11. After a divider write at edge D, the k-th increment lands on edge D + k*P + 1.
- R4: While the run bit has been clear for two consecutive cycles, the counter holds its value.
- R5: A tick that finds the counter at 0xFF loads the modulo value on that same edge instead of wrapping to 0x00.
- R6: Each overflow drives `irq_o` high for exactly one clock, in the cycle where the counter first shows the reloaded value.
- R7: A write to the divider address clears the whole 16-bit prescaler to zero. The divider reads prescaler bits 15:8, so it advances once every 256 clocks.
- R8: A bus write to the counter on the same edge as a tick wins: the counter takes the written value, and neither an increment nor an interrupt occurs.
- R9: Clearing the run bit while the selected prescaler bit is high produces one extra increment, because the gated tap falls.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| addr_i | input | 2 | Register select |
| wr_i | input | 1 | Write strobe, one clock per write |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data for the register at `addr_i` (combinational) |
| irq_o | output | 1 | Overflow interrupt request pulse |

## Verification
The properties assume that each write strobe lasts exactly one clock. They also assume that the address is stable whenever the strobe is high, so that every counter or divider write is an unambiguous single event. The step and hold properties take for granted that the minimum tap spacing keeps two falling edges of one prescaler bit at least two clocks apart, which holds for every tap choice. The bench drives address, data and strobe only at falling clock edges and releases the strobe after one rising edge. It clears the prescaler before each timed sweep so that every tick lands on a cycle the bench can compute. It samples counts in the middle of a tick period, except for the deliberate same-edge write and run-bit glitch cases.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
   localparam int ADDR_W = 2;
   localparam int CTL_W  = 3;

   typedef enum logic [ADDR_W-1:0] {
      REG_DIV = 2'd0,
      REG_CNT = 2'd1,
      REG_MOD = 2'd2,
      REG_CTL = 2'd3
   } reg_sel_e;

   typedef struct packed {
      logic       run;
      logic [1:0] rate;
   } ctl_t;
endpackage

// File: rtl/tmr_prescaler.sv
module tmr_prescaler #(
   parameter int PRE_W = 16
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             clr_i,
   output logic [PRE_W-1:0] val_o
);
   always_ff @(posedge clk_i) begin
      if (!rst_ni)    val_o <= '0;
      else if (clr_i) val_o <= '0;
      else            val_o <= val_o + 1'b1;
   end
endmodule

// File: rtl/tmr_tap_edge.sv
module tmr_tap_edge #(
   parameter int PRE_W    = 16,
   parameter int TAP_SEL0 = 9,
   parameter int TAP_SEL1 = 3,
   parameter int TAP_SEL2 = 5,
   parameter int TAP_SEL3 = 7
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic [PRE_W-1:0] pre_i,
   input  logic [1:0]       rate_i,
   input  logic             run_i,
   output logic             tick_o
);
   localparam int N_RATES = 4;

   function automatic int tap_pos(input int idx);
      case (idx)
         0:       return TAP_SEL0;
         1:       return TAP_SEL1;
         2:       return TAP_SEL2;
         default: return TAP_SEL3;
      endcase
   endfunction

   logic [N_RATES-1:0] taps;
   logic               gated;
   logic               gated_q;
   logic               unused_pre;

   for (genvar g = 0; g < N_RATES; g++) begin : g_tap
      assign taps[g] = pre_i[tap_pos(g)];
   end

   assign unused_pre = ^pre_i;
   assign gated      = taps[rate_i] & run_i;

   always_ff @(posedge clk_i) begin
      if (!rst_ni) gated_q <= 1'b0;
      else         gated_q <= gated;
   end

   assign tick_o = gated_q & ~gated;
endmodule

// File: rtl/tmr_counter.sv
module tmr_counter #(
   parameter int CNT_W = 8
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             tick_i,
   input  logic             cnt_we_i,
   input  logic             mod_we_i,
   input  logic [CNT_W-1:0] wdata_i,
   output logic [CNT_W-1:0] cnt_o,
   output logic [CNT_W-1:0] mod_o,
   output logic             irq_o
);
   localparam logic [CNT_W-1:0] CNT_TOP = '1;

   always_ff @(posedge clk_i) begin
      if (!rst_ni) begin
         cnt_o <= '0;
         irq_o <= 1'b0;
      end else begin
         irq_o <= 1'b0;
         if (cnt_we_i) begin
            cnt_o <= wdata_i;
         end else if (tick_i) begin
            if (cnt_o == CNT_TOP) begin
               cnt_o <= mod_o;
               irq_o <= 1'b1;
            end else begin
               cnt_o <= cnt_o + 1'b1;
            end
         end
      end
   end

   always_ff @(posedge clk_i) begin
      if (!rst_ni)       mod_o <= '0;
      else if (mod_we_i) mod_o <= wdata_i;
   end
endmodule

// File: rtl/prog_timer.sv
module prog_timer
   import tmr_pkg::*;
#(
   parameter int CNT_W    = 8,
   parameter int PRE_W    = 16,
   parameter int TAP_SEL0 = 9,
   parameter int TAP_SEL1 = 3,
   parameter int TAP_SEL2 = 5,
   parameter int TAP_SEL3 = 7
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic [ADDR_W-1:0] addr_i,
   input  logic              wr_i,
   input  logic [CNT_W-1:0]  wdata_i,
   output logic [CNT_W-1:0]  rdata_o,
   output logic              irq_o
);
   localparam int DIV_LSB = PRE_W - CNT_W;

   if (PRE_W < CNT_W) begin : g_bad_pre
      $error("prescaler narrower than divider read port");
   end
   if (CNT_W < CTL_W) begin : g_bad_cnt
      $error("data width cannot hold the control field");
   end
   if (TAP_SEL0 >= PRE_W || TAP_SEL1 >= PRE_W ||
       TAP_SEL2 >= PRE_W || TAP_SEL3 >= PRE_W) begin : g_bad_tap
      $error("rate tap outside the prescaler");
   end

   logic             wr_div, wr_cnt, wr_mod, wr_ctl;
   logic [PRE_W-1:0] pre_q;
   logic [CNT_W-1:0] cnt_q, mod_q;
   ctl_t             ctl_q;
   logic             run_w;
   logic             tick;

   assign wr_div = wr_i && (addr_i == REG_DIV);
   assign wr_cnt = wr_i && (addr_i == REG_CNT);
   assign wr_mod = wr_i && (addr_i == REG_MOD);
   assign wr_ctl = wr_i && (addr_i == REG_CTL);
   assign run_w  = ctl_q.run;

   always_ff @(posedge clk_i) begin
      if (!rst_ni)     ctl_q <= '0;
      else if (wr_ctl) ctl_q <= ctl_t'(wdata_i[CTL_W-1:0]);
   end

   tmr_prescaler #(.PRE_W(PRE_W)) u_prescaler (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .clr_i  (wr_div),
      .val_o  (pre_q)
   );

   tmr_tap_edge #(
      .PRE_W    (PRE_W),
      .TAP_SEL0 (TAP_SEL0),
      .TAP_SEL1 (TAP_SEL1),
      .TAP_SEL2 (TAP_SEL2),
      .TAP_SEL3 (TAP_SEL3)
   ) u_tap_edge (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .pre_i  (pre_q),
      .rate_i (ctl_q.rate),
      .run_i  (run_w),
      .tick_o (tick)
   );

   tmr_counter #(.CNT_W(CNT_W)) u_counter (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .tick_i   (tick),
      .cnt_we_i (wr_cnt),
      .mod_we_i (wr_mod),
      .wdata_i  (wdata_i),
      .cnt_o    (cnt_q),
      .mod_o    (mod_q),
      .irq_o    (irq_o)
   );

   always_comb begin
      rdata_o = '0;
      case (addr_i)
         REG_DIV: rdata_o = pre_q[PRE_W-1:DIV_LSB];
         REG_CNT: rdata_o = cnt_q;
         REG_MOD: rdata_o = mod_q;
         default: rdata_o[CTL_W-1:0] = ctl_q;
      endcase
   end
endmodule

// File: rtl/tmr_checker.sv
module tmr_checker
   import tmr_pkg::*;
#(
   parameter int CNT_W = 8,
   parameter int PRE_W = 16
) (
   input logic              clk,
   input logic              rst_n,
   input logic [ADDR_W-1:0] addr,
   input logic              wr,
   input logic [CNT_W-1:0]  wdata,
   input logic [CNT_W-1:0]  cnt,
   input logic [CNT_W-1:0]  mod,
   input logic [PRE_W-1:0]  pre,
   input logic              run,
   input logic              irq
);
   // R8: a counter write always lands, tick or not
   assert_cnt_write_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (wr && addr == REG_CNT) |=> (cnt == $past(wdata)));

   // R7: divider write zeroes the prescaler
   assert_div_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (wr && addr == REG_DIV) |=> (pre == '0));

   // R6: the request never lasts two cycles
   assert_irq_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
      irq |=> !irq);

   // R5: a request means the counter was at top and took the modulo value
   assert_reload_R5: assert property (@(posedge clk) disable iff (!rst_n)
      irq |-> (cnt == $past(mod) && $past(cnt) == '1));

   // R3: without a write the counter only holds, steps by one, or reloads
   assert_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
      !(wr && addr == REG_CNT) |=>
         (cnt == $past(cnt) || cnt == $past(cnt) + 1'b1 || irq));

   // R4: stopped long enough means no movement
   assert_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (!run && $past(!run) && !(wr && addr == REG_CNT)) |=> $stable(cnt));
endmodule

bind prog_timer tmr_checker #(.CNT_W(CNT_W), .PRE_W(PRE_W)) u_tmr_checker (
   .clk   (clk_i),
   .rst_n (rst_ni),
   .addr  (addr_i),
   .wr    (wr_i),
   .wdata (wdata_i),
   .cnt   (cnt_q),
   .mod   (mod_q),
   .pre   (pre_q),
   .run   (run_w),
   .irq   (irq_o)
);

// File: tb/prog_timer_bench.sv
`timescale 1ns/1ps
module prog_timer_bench;
   localparam logic [1:0] A_DIV = 2'd0;
   localparam logic [1:0] A_CNT = 2'd1;
   localparam logic [1:0] A_MOD = 2'd2;
   localparam logic [1:0] A_CTL = 2'd3;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [1:0] addr = 2'd0;
   logic       wr = 1'b0;
   logic [7:0] wdata = 8'h00;
   logic [7:0] rdata;
   logic       irq;

   int n_chk = 0;
   int n_fail = 0;

   always #10 clk = ~clk;

   prog_timer u_prog_timer (
      .clk_i   (clk),
      .rst_ni  (rst_n),
      .addr_i  (addr),
      .wr_i    (wr),
      .wdata_i (wdata),
      .rdata_o (rdata),
      .irq_o   (irq)
   );

   task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   // called at a falling edge; returns at the falling edge after the write
   task automatic wr_reg(input logic [1:0] a, input logic [7:0] d);
      addr = a; wdata = d; wr = 1'b1;
      @(posedge clk);
      @(negedge clk);
      wr = 1'b0;
   endtask

   task automatic rd_reg(input logic [1:0] a, output logic [7:0] d);
      addr = a;
      #1 d = rdata;
   endtask

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   function automatic int period_of(input int rate);
      case (rate)
         0: return 1024;
         1: return 16;
         2: return 64;
         default: return 256;
      endcase
   endfunction

   initial begin
      repeat (200000) @(posedge clk);
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin
      logic [7:0] v;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R1: reset state
      rd_reg(A_DIV, v); check("R1 divider", v, 8'h00);
      rd_reg(A_CNT, v); check("R1 counter", v, 8'h00);
      rd_reg(A_MOD, v); check("R1 modulo", v, 8'h00);
      rd_reg(A_CTL, v); check("R1 control", v, 8'h00);
      check("R1 irq", {7'd0, irq}, 8'h00);

      // R3 and R7: every rate, three ticks after a prescaler clear
      for (int rate = 0; rate < 4; rate++) begin
         int p;
         int n;
         p = period_of(rate);
         wr_reg(A_CTL, 8'h04 | 8'(rate));
         wr_reg(A_DIV, 8'h00);
         wr_reg(A_CNT, 8'h10);
         n = 3 * p + p / 2;
         idle(n - 1);
         rd_reg(A_CNT, v); check($sformatf("R3 rate %0d count", rate), v, 8'h13);
         rd_reg(A_DIV, v); check($sformatf("R7 divider at rate %0d", rate), v, 8'((n >> 8) & 255));
      end

      // R5 and R6: overflow reloads from modulo with a single-cycle request
      wr_reg(A_MOD, 8'hC0);
      wr_reg(A_CTL, 8'h05);
      wr_reg(A_DIV, 8'h00);
      wr_reg(A_CNT, 8'hFE);
      idle(31);
      rd_reg(A_CNT, v); check("R5 before overflow", v, 8'hFF);
      check("R6 irq low before overflow", {7'd0, irq}, 8'h00);
      idle(1);
      rd_reg(A_CNT, v); check("R5 reload value", v, 8'hC0);
      check("R6 irq high on reload", {7'd0, irq}, 8'h01);
      idle(1);
      check("R6 irq back low", {7'd0, irq}, 8'h00);
      idle(22);
      rd_reg(A_CNT, v); check("R5 count continues from modulo", v, 8'hC1);

      // R5 and R2: sweep of modulo values
      for (int i = 0; i < 8; i++) begin
         logic [7:0] m;
         m = (i == 7) ? 8'hFF : 8'(i * 36);
         wr_reg(A_MOD, m);
         rd_reg(A_MOD, v); check("R2 modulo readback", v, m);
         wr_reg(A_DIV, 8'h00);
         wr_reg(A_CNT, 8'hFF);
         idle(16);
         rd_reg(A_CNT, v); check($sformatf("R5 reload to %h", m), v, m);
         check("R6 irq on sweep reload", {7'd0, irq}, 8'h01);
      end

      // R8: counter write on the tick edge wins
      wr_reg(A_DIV, 8'h00);
      wr_reg(A_CNT, 8'h50);
      idle(15);
      wr_reg(A_CNT, 8'h80);
      rd_reg(A_CNT, v); check("R8 write beats tick", v, 8'h80);
      check("R8 no irq", {7'd0, irq}, 8'h00);
      idle(23);
      rd_reg(A_CNT, v); check("R8 next tick increments written value", v, 8'h81);

      // R9: clearing run while the tap is high gives one extra count
      wr_reg(A_DIV, 8'h00);
      wr_reg(A_CNT, 8'h20);
      idle(9);
      wr_reg(A_CTL, 8'h01);
      idle(189);
      rd_reg(A_CNT, v); check("R9 extra tick on stop", v, 8'h21);

      // R4: stopped counter holds over many periods
      wr_reg(A_DIV, 8'h00);
      wr_reg(A_CNT, 8'h33);
      idle(3000);
      rd_reg(A_CNT, v); check("R4 hold while stopped", v, 8'h33);

      // R2: control keeps only three bits
      wr_reg(A_CTL, 8'hFF);
      rd_reg(A_CTL, v); check("R2 control readback", v, 8'h07);

      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end
endmodule